// File: doc/BRIEF.md
# Pipeline Operand Forwarding Selector

This block sits in the decode stage of a five-stage in-order pipeline and chooses the two operand values, A and B, handed to the execute stage. An operand normally comes from the register file. When an older instruction still in flight will write the register being read, the block takes the newest in-flight value instead. Five result paths are candidates:
- the result the execute-stage ALU produces in the current cycle;
- the data read from memory in the memory stage;
- the ALU result held in the memory stage;
- the memory value held in the write-back stage;
- the ALU result held in the write-back stage.

Operand A also carries the incremented PC for call and jump instructions. The selection logic is purely combinational. Its two results are captured in the operand fields of the execute pipeline register, and that register is part of this block. Stalling for values that cannot be forwarded is handled by a separate control block.

Top module: `opfwd_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, both `opnd_a_q` and `opnd_b_q` become 0 after that edge.
- R2: When `dec_class` is 2'b01 (call) or 2'b10 (jump), `opnd_a_q` takes `dec_next_pc`, whatever any destination ID matches. Class 2'b00 (plain) and class 2'b11 (return) never select the incremented PC.
- R3: For operand A, when the class is neither call nor jump, the first match in this fixed priority list wins:
  1. `ex_dst_e`, which gives `ex_alu_res`;
  2. `mem_dst_m`, which gives `mem_rd_data`;
  3. `mem_dst_e`, which gives `mem_alu_val`;
  4. `wb_dst_m`, which gives `wb_mem_val`;
  5. `wb_dst_e`, which gives `wb_alu_val`.

  A match means that the destination ID equals `dec_src_a`. An ID that matches both an execute and a write-back destination takes the execute value.
- R4: If no destination matches a source ID, the operand takes its register-file read data (`rf_data_a` or `rf_data_b`).
- R5: Register ID 4'hF means "no register". A source ID of 4'hF gives the register-file data even when destination IDs are also 4'hF. A destination of 4'hF never matches a real source ID.
- R6: Operand B uses the same five-source priority on `dec_src_b`, with `rf_data_b` as its fallback. `dec_class` has no effect on operand B.
- R7: Both operands are registered. Values selected from the inputs present at a rising edge appear on the outputs after that edge and stay unchanged until the next edge.
- R8: Operands A and B are selected independently, so in one cycle they may come from different sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_src_a | input | 4 | Decode source register ID for operand A (4'hF = none) |
| dec_src_b | input | 4 | Decode source register ID for operand B (4'hF = none) |
| rf_data_a | input | 32 | Register-file read data for operand A |
| rf_data_b | input | 32 | Register-file read data for operand B |
| dec_class | input | 2 | Decoded class: 00 plain, 01 call, 10 jump, 11 return |
| dec_next_pc | input | 32 | Incremented PC of the decode instruction |
| ex_dst_e | input | 4 | Execute-stage ALU destination ID |
| ex_alu_res | input | 32 | ALU result computed in execute this cycle |
| mem_dst_m | input | 4 | Memory-stage load destination ID |
| mem_rd_data | input | 32 | Data read from memory this cycle |
| mem_dst_e | input | 4 | Memory-stage ALU destination ID |
| mem_alu_val | input | 32 | ALU result held in the memory stage |
| wb_dst_m | input | 4 | Write-back load destination ID |
| wb_mem_val | input | 32 | Memory value held in the write-back stage |
| wb_dst_e | input | 4 | Write-back ALU destination ID |
| wb_alu_val | input | 32 | ALU result held in the write-back stage |
| opnd_a_q | output | 32 | Registered operand A for execute |
| opnd_b_q | output | 32 | Registered operand B for execute |

## Verification
The bench builds the block with its default 4-bit register IDs and 32-bit data. This makes a near-exhaustive sweep practical:
- every real source ID;
- all 32 combinations of which of the five destinations match;
- all four instruction classes.

Each pending value carries a tag for its source, so a wrong priority choice shows up directly in the output. Destinations that do not match are set either to 4'hF or to other real IDs. Directed cases cover the "no register" ID on both sides, a double execute/write-back match, and the one-cycle register delay.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

  localparam int REG_W   = 4;
  localparam int DATA_W  = 32;
  localparam int NSRC    = 5;
  localparam int CLS_W   = 2;

  // Source slots in priority order (index 0 wins)
  localparam int SLOT_EX_E  = 0;
  localparam int SLOT_MEM_M = 1;
  localparam int SLOT_MEM_E = 2;
  localparam int SLOT_WB_M  = 3;
  localparam int SLOT_WB_E  = 4;

  typedef enum logic [CLS_W-1:0] {
    CLS_PLAIN  = 2'b00,
    CLS_CALL   = 2'b01,
    CLS_JUMP   = 2'b10,
    CLS_RETURN = 2'b11
  } instr_cls_e;

  // Classes whose operand A carries the incremented PC
  function automatic logic takes_link_pc(input logic [CLS_W-1:0] cls);
    return (cls == CLS_CALL) || (cls == CLS_JUMP);
  endfunction

endpackage

// File: rtl/opfwd_match.sv
// Compares one source ID against every pending destination ID.
module opfwd_match #(
  parameter int REG_W = 4,
  parameter int NSRC  = 5
) (
  input  logic [REG_W-1:0] src_id,
  input  logic [REG_W-1:0] dst_ids [NSRC],
  output logic [NSRC-1:0]  hit
);
  localparam logic [REG_W-1:0] NONE_ID = {REG_W{1'b1}};

  logic src_real;
  assign src_real = (src_id != NONE_ID);

  for (genvar i = 0; i < NSRC; i++) begin : g_cmp
    assign hit[i] = src_real && (dst_ids[i] == src_id);
  end
endmodule

// File: rtl/opfwd_prio.sv
// Fixed-priority selector: slot 0 wins, fallback when nothing hits.
module opfwd_prio #(
  parameter int DATA_W = 32,
  parameter int NSRC   = 5
) (
  input  logic [NSRC-1:0]   hit,
  input  logic [DATA_W-1:0] vals [NSRC],
  input  logic [DATA_W-1:0] fallback,
  output logic [DATA_W-1:0] pick
);
  logic [DATA_W-1:0] chain [NSRC+1];

  assign chain[NSRC] = fallback;

  for (genvar i = NSRC - 1; i >= 0; i--) begin : g_chain
    assign chain[i] = hit[i] ? vals[i] : chain[i+1];
  end

  assign pick = chain[0];
endmodule

// File: rtl/opfwd_operand.sv
// One operand path: match stage followed by priority select.
module opfwd_operand #(
  parameter int REG_W  = 4,
  parameter int DATA_W = 32,
  parameter int NSRC   = 5
) (
  input  logic [REG_W-1:0]  src_id,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [REG_W-1:0]  dst_ids [NSRC],
  input  logic [DATA_W-1:0] vals    [NSRC],
  output logic [DATA_W-1:0] sel_val
);
  logic [NSRC-1:0] hit;

  opfwd_match #(.REG_W(REG_W), .NSRC(NSRC)) u_match (
    .src_id  (src_id),
    .dst_ids (dst_ids),
    .hit     (hit)
  );

  opfwd_prio #(.DATA_W(DATA_W), .NSRC(NSRC)) u_prio (
    .hit      (hit),
    .vals     (vals),
    .fallback (rf_val),
    .pick     (sel_val)
  );
endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
  import opfwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  dec_src_a,
  input  logic [REG_W-1:0]  dec_src_b,
  input  logic [DATA_W-1:0] rf_data_a,
  input  logic [DATA_W-1:0] rf_data_b,
  input  logic [CLS_W-1:0]  dec_class,
  input  logic [DATA_W-1:0] dec_next_pc,
  input  logic [REG_W-1:0]  ex_dst_e,
  input  logic [DATA_W-1:0] ex_alu_res,
  input  logic [REG_W-1:0]  mem_dst_m,
  input  logic [DATA_W-1:0] mem_rd_data,
  input  logic [REG_W-1:0]  mem_dst_e,
  input  logic [DATA_W-1:0] mem_alu_val,
  input  logic [REG_W-1:0]  wb_dst_m,
  input  logic [DATA_W-1:0] wb_mem_val,
  input  logic [REG_W-1:0]  wb_dst_e,
  input  logic [DATA_W-1:0] wb_alu_val,
  output logic [DATA_W-1:0] opnd_a_q,
  output logic [DATA_W-1:0] opnd_b_q
);

  logic [REG_W-1:0]  pend_dst [NSRC];
  logic [DATA_W-1:0] pend_val [NSRC];

  // Pack the pending results in priority order
  assign pend_dst[SLOT_EX_E]  = ex_dst_e;
  assign pend_val[SLOT_EX_E]  = ex_alu_res;
  assign pend_dst[SLOT_MEM_M] = mem_dst_m;
  assign pend_val[SLOT_MEM_M] = mem_rd_data;
  assign pend_dst[SLOT_MEM_E] = mem_dst_e;
  assign pend_val[SLOT_MEM_E] = mem_alu_val;
  assign pend_dst[SLOT_WB_M]  = wb_dst_m;
  assign pend_val[SLOT_WB_M]  = wb_mem_val;
  assign pend_dst[SLOT_WB_E]  = wb_dst_e;
  assign pend_val[SLOT_WB_E]  = wb_alu_val;

  logic [DATA_W-1:0] fwd_a, fwd_b, next_a;

  opfwd_operand #(.REG_W(REG_W), .DATA_W(DATA_W), .NSRC(NSRC)) u_opa (
    .src_id  (dec_src_a),
    .rf_val  (rf_data_a),
    .dst_ids (pend_dst),
    .vals    (pend_val),
    .sel_val (fwd_a)
  );

  opfwd_operand #(.REG_W(REG_W), .DATA_W(DATA_W), .NSRC(NSRC)) u_opb (
    .src_id  (dec_src_b),
    .rf_val  (rf_data_b),
    .dst_ids (pend_dst),
    .vals    (pend_val),
    .sel_val (fwd_b)
  );

  // Incremented PC outranks every forwarding choice on operand A
  always_comb begin
    next_a = fwd_a;
    if (takes_link_pc(dec_class)) next_a = dec_next_pc;
  end

  // Operand fields of the execute pipeline register
  always_ff @(posedge clk) begin
    if (rst) begin
      opnd_a_q <= '0;
      opnd_b_q <= '0;
    end else begin
      opnd_a_q <= next_a;
      opnd_b_q <= fwd_b;
    end
  end

endmodule

// File: rtl/opfwd_unit_chk.sv
module opfwd_unit_chk
  import opfwd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [REG_W-1:0]  dec_src_a,
  input logic [REG_W-1:0]  dec_src_b,
  input logic [DATA_W-1:0] rf_data_a,
  input logic [DATA_W-1:0] rf_data_b,
  input logic [CLS_W-1:0]  dec_class,
  input logic [DATA_W-1:0] dec_next_pc,
  input logic [REG_W-1:0]  ex_dst_e,
  input logic [DATA_W-1:0] ex_alu_res,
  input logic [REG_W-1:0]  mem_dst_m,
  input logic [REG_W-1:0]  mem_dst_e,
  input logic [REG_W-1:0]  wb_dst_m,
  input logic [REG_W-1:0]  wb_dst_e,
  input logic [DATA_W-1:0] wb_alu_val,
  input logic [DATA_W-1:0] opnd_a_q,
  input logic [DATA_W-1:0] opnd_b_q
);
  localparam logic [REG_W-1:0] NONE_ID = {REG_W{1'b1}};

  logic a_link;
  assign a_link = (dec_class == 2'b01) || (dec_class == 2'b10);

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (opnd_a_q == '0 && opnd_b_q == '0));

  p_link_pc_r2: assert property (@(posedge clk) disable iff (rst)
    a_link |=> opnd_a_q == $past(dec_next_pc));

  p_ex_first_r3: assert property (@(posedge clk) disable iff (rst)
    (!a_link && dec_src_a != NONE_ID && dec_src_a == ex_dst_e)
    |=> opnd_a_q == $past(ex_alu_res));

  p_wb_e_last_r3: assert property (@(posedge clk) disable iff (rst)
    (!a_link && dec_src_a != NONE_ID && dec_src_a == wb_dst_e &&
     dec_src_a != ex_dst_e && dec_src_a != mem_dst_m &&
     dec_src_a != mem_dst_e && dec_src_a != wb_dst_m)
    |=> opnd_a_q == $past(wb_alu_val));

  p_rf_fallback_r4: assert property (@(posedge clk) disable iff (rst)
    (dec_src_b != ex_dst_e && dec_src_b != mem_dst_m &&
     dec_src_b != mem_dst_e && dec_src_b != wb_dst_m &&
     dec_src_b != wb_dst_e)
    |=> opnd_b_q == $past(rf_data_b));

  p_none_id_r5: assert property (@(posedge clk) disable iff (rst)
    (!a_link && dec_src_a == NONE_ID) |=> opnd_a_q == $past(rf_data_a));

  p_b_ex_first_r6: assert property (@(posedge clk) disable iff (rst)
    (dec_src_b != NONE_ID && dec_src_b == ex_dst_e)
    |=> opnd_b_q == $past(ex_alu_res));

endmodule

bind opfwd_unit opfwd_unit_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .dec_src_a   (dec_src_a),
  .dec_src_b   (dec_src_b),
  .rf_data_a   (rf_data_a),
  .rf_data_b   (rf_data_b),
  .dec_class   (dec_class),
  .dec_next_pc (dec_next_pc),
  .ex_dst_e    (ex_dst_e),
  .ex_alu_res  (ex_alu_res),
  .mem_dst_m   (mem_dst_m),
  .mem_dst_e   (mem_dst_e),
  .wb_dst_m    (wb_dst_m),
  .wb_dst_e    (wb_dst_e),
  .wb_alu_val  (wb_alu_val),
  .opnd_a_q    (opnd_a_q),
  .opnd_b_q    (opnd_b_q)
);

// File: tb/opfwd_unit_tb.sv
`timescale 1ns/1ps
module opfwd_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  dec_src_a, dec_src_b;
  logic [31:0] rf_data_a, rf_data_b;
  logic [1:0]  dec_class;
  logic [31:0] dec_next_pc;
  logic [3:0]  dst [5];
  logic [31:0] val [5];
  logic [31:0] opnd_a_q, opnd_b_q;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  opfwd_unit u_dut (
    .clk(clk), .rst(rst),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .rf_data_a(rf_data_a), .rf_data_b(rf_data_b),
    .dec_class(dec_class), .dec_next_pc(dec_next_pc),
    .ex_dst_e(dst[0]),  .ex_alu_res(val[0]),
    .mem_dst_m(dst[1]), .mem_rd_data(val[1]),
    .mem_dst_e(dst[2]), .mem_alu_val(val[2]),
    .wb_dst_m(dst[3]),  .wb_mem_val(val[3]),
    .wb_dst_e(dst[4]),  .wb_alu_val(val[4]),
    .opnd_a_q(opnd_a_q), .opnd_b_q(opnd_b_q)
  );

  // Reference model written from the requirement text (R3, R4, R5, R6)
  function automatic logic [31:0] ref_pick(input logic [3:0] src, input logic [31:0] rf);
    if (src == 4'hF) return rf;
    for (int k = 0; k < 5; k++)
      if (dst[k] == src) return val[k];
    return rf;
  endfunction

  function automatic bit is_link(input logic [1:0] c);
    return (c == 2'b01) || (c == 2'b10);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at negedge, clock through one edge, sample at the following negedge
  task automatic step_and_check(input string tag_a, input string tag_b);
    logic [31:0] ea, eb;
    ea = is_link(dec_class) ? dec_next_pc : ref_pick(dec_src_a, rf_data_a);
    eb = ref_pick(dec_src_b, rf_data_b);
    @(posedge clk);
    @(negedge clk);
    check(tag_a, opnd_a_q, ea);
    check(tag_b, opnd_b_q, eb);
  endtask

  task automatic load_vals(input int it);
    for (int k = 0; k < 5; k++) val[k] = 32'h1111_0000 * (k + 1) + it;
    rf_data_a   = 32'hA0A0_0000 + it;
    rf_data_b   = 32'hB0B0_0000 + it;
    dec_next_pc = 32'h0000_C000 + it;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int it = 0;
    rst = 1'b1;
    dec_src_a = 4'h1; dec_src_b = 4'h2; dec_class = 2'b01;
    for (int k = 0; k < 5; k++) dst[k] = 4'h1;
    load_vals(7);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset a", opnd_a_q, 32'h0);
    check("R1 reset b", opnd_b_q, 32'h0);
    rst = 1'b0;

    // Sweep: source ID x match mask x class
    for (int s = 0; s < 15; s++) begin
      for (int m = 0; m < 32; m++) begin
        for (int c = 0; c < 4; c++) begin
          logic [3:0] sa, sb, tgt;
          string ta;
          sa = 4'(s);
          sb = 4'((s + 7) % 15);
          tgt = c[0] ? sb : sa;
          for (int k = 0; k < 5; k++) begin
            if (m[k]) dst[k] = tgt;
            else if (k[0]) dst[k] = 4'hF;
            else dst[k] = 4'((int'(tgt) + 1 + k) % 15);
          end
          dec_src_a = sa;
          dec_src_b = sb;
          dec_class = 2'(c);
          load_vals(it);
          it++;
          if (is_link(dec_class)) ta = "R2 link pc a";
          else if (ref_pick(sa, 32'hDEAD_BEEF) == 32'hDEAD_BEEF) ta = "R4 rf a";
          else ta = "R3 prio a";
          step_and_check(ta, "R6 prio b R8");
        end
      end
    end

    // R5: no-register source against no-register destinations
    for (int k = 0; k < 5; k++) dst[k] = 4'hF;
    dec_src_a = 4'hF; dec_src_b = 4'hF; dec_class = 2'b00;
    load_vals(900);
    step_and_check("R5 none src a", "R5 none src b");
    // R5: real source, all destinations are no-register
    dec_src_a = 4'h3; dec_src_b = 4'h0;
    load_vals(901);
    step_and_check("R5 none dst a", "R5 none dst b");

    // R3: double match execute and write-back, execute wins
    for (int k = 0; k < 5; k++) dst[k] = 4'h9;
    dst[0] = 4'h6; dst[4] = 4'h6;
    dec_src_a = 4'h6; dec_src_b = 4'h6; dec_class = 2'b11;
    load_vals(902);
    step_and_check("R3 ex over wb a", "R6 ex over wb b");

    // R2: link outranks a full match while B still forwards
    for (int k = 0; k < 5; k++) dst[k] = 4'h4;
    dec_src_a = 4'h4; dec_src_b = 4'h4; dec_class = 2'b10;
    load_vals(903);
    step_and_check("R2 jump over match", "R6 class ignored b");

    // R7: new inputs do not reach the outputs before the next edge
    begin
      logic [31:0] hold_a, hold_b;
      hold_a = opnd_a_q;
      hold_b = opnd_b_q;
      dec_src_a = 4'h2; dec_class = 2'b00;
      for (int k = 0; k < 5; k++) dst[k] = 4'hF;
      load_vals(904);
      #1;
      check("R7 hold a", opnd_a_q, hold_a);
      check("R7 hold b", opnd_b_q, hold_b);
      step_and_check("R7 update a", "R7 update b");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule